// File: doc/BRIEF.md
# Global-history correlating branch direction predictor

This block predicts whether a conditional branch is taken. A global history register keeps the outcomes of the most recent M resolved branches. The history is joined with the low K bits of the fetch address, and the result selects one of 2^(M+K) saturating counters, each N bits wide. One static branch therefore has 2^M counters, and the pattern of its neighbours' recent outcomes chooses among them. The storage is 2^M × 2^K × N bits, which is 128 bits for M=2, N=2, K=4.

The fetch side presents a PC and receives a combinational taken/not-taken answer in the same cycle. It also receives the history value that the lookup used, and it keeps that value with the branch. When the branch resolves, the execute side returns the PC, that history value and the real outcome. The block then trains the same counter the lookup read and shifts the outcome into the global history.

Top module: `corr_bp`

## Requirements
- R1: After reset, every counter holds the weakly-taken value 2^(N-1), the history is zero, and a lookup at any PC predicts taken.
- R2: `lk_taken_o` is 1 exactly when the most significant bit of the selected counter is 1.
- R3: The lookup index is {history, PC[K-1:0]}, with the history in the upper M bits. PC bits at K and above have no effect on the prediction.
- R4: An update trains the counter at index {up_hist_i, up_pc_i[K-1:0]}. A taken outcome increments it and a not-taken outcome decrements it. The counter saturates at 2^N-1 and at 0 and never wraps.
- R5: With N=2, a counter that is saturated in one direction keeps its prediction after one opposite outcome and flips after the second.
- R6: On each valid update the outcome enters history bit 0 and the oldest bit is dropped. `lk_hist_o` shows the current history.
- R7: A lookup reflects the table contents before any update in the same cycle. The update is seen from the next cycle.
- R8: With M=0 the block is a plain PC-indexed counter table, and `lk_hist_o` stays 0.
- R9: When `up_valid_i` is low, no counter and no history bit changes.
- R10: With M≥1, if branch B always repeats the outcome of the branch A just before it, and A alternates, both branches reach zero mispredictions after a warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | PC_W | PC presented for lookup |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| lk_hist_o | output | max(M,1) | History used by this lookup, to be returned with the update |
| up_valid_i | input | 1 | A resolved branch is presented |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_hist_i | input | max(M,1) | History the branch saw at lookup (ignored when M=0) |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds two instances. The first uses M=2, N=2, K=4, which is the 128-bit table; with it the correlated alternating pair, the two-miss flip and the stale-history update are all reachable. The second uses M=0, N=3, K=3. It shows the plain PC-indexed table on the same stimulus, where the correlated pair keeps mispredicting, and it reaches both saturation limits of a wider counter. Both instances are compared every cycle against a model. The random PCs carry noise in their upper bits, and the random updates carry histories that differ from the current global history.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {DIR_NT = 1'b0, DIR_T = 1'b1} dir_e;

  // saturating step of a w-bit counter
  function automatic int unsigned sat_step(int unsigned v, logic inc, int unsigned w);
    int unsigned top;
    top = (32'd1 << w) - 32'd1;
    if (inc) return (v >= top) ? top : v + 32'd1;
    else     return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int unsigned M  = 2,
  parameter int unsigned HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          taken_i,
  output logic [HW-1:0] hist_o
);
  if (M > 0) begin : g_hist
    logic [HW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (shift_i) q <= HW'({q, taken_i});
    end
    assign hist_o = q;
  end else begin : g_nohist
    logic unused_in;
    assign unused_in = shift_i ^ taken_i;
    assign hist_o    = '0;
  end
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned M    = 2,
  parameter int unsigned K    = 4,
  parameter int unsigned PC_W = 32,
  parameter int unsigned HW   = 2,
  parameter int unsigned IW   = 6
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [HW-1:0]   hist_i,
  output logic [IW-1:0]   idx_o
);
  logic unused_pc;
  assign unused_pc = ^pc_i[PC_W-1:K];

  if (M > 0) begin : g_corr
    assign idx_o = {hist_i, pc_i[K-1:0]};
  end else begin : g_flat
    logic unused_hist;
    assign unused_hist = ^hist_i;
    assign idx_o       = pc_i[K-1:0];
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [N-1:0]  rd_ctr_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_taken_i,
  output logic [N-1:0]  wr_ctr_o
);
  localparam int unsigned DEPTH = 1 << IW;
  localparam logic [N-1:0] WEAK_T = N'(1 << (N - 1));

  logic [N-1:0] mem [DEPTH];
  logic [N-1:0] nxt;

  assign rd_ctr_o = mem[rd_idx_i];
  assign wr_ctr_o = mem[wr_idx_i];
  assign nxt      = N'(sat_step(32'(wr_ctr_o), wr_taken_i, N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= WEAK_T;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/corr_bp.sv
module corr_bp
  import bp_pkg::*;
#(
  parameter int unsigned M    = 2,
  parameter int unsigned N    = 2,
  parameter int unsigned K    = 4,
  parameter int unsigned PC_W = 32,
  localparam int unsigned HW  = (M > 0) ? M : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  output logic [HW-1:0]   lk_hist_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic [HW-1:0]   up_hist_i,
  input  logic            up_taken_i
);
  localparam int unsigned IW = M + K;

  logic [HW-1:0] ghr;
  logic [IW-1:0] lk_idx, up_idx;
  logic [N-1:0]  lk_ctr, up_ctr;
  dir_e          up_dir;

  assign up_dir = dir_e'(up_taken_i);

  bp_ghr #(.M(M), .HW(HW)) u_ghr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (up_valid_i),
    .taken_i (up_dir == DIR_T),
    .hist_o  (ghr)
  );

  bp_index #(.M(M), .K(K), .PC_W(PC_W), .HW(HW), .IW(IW)) u_lk_idx (
    .pc_i   (lk_pc_i),
    .hist_i (ghr),
    .idx_o  (lk_idx)
  );

  bp_index #(.M(M), .K(K), .PC_W(PC_W), .HW(HW), .IW(IW)) u_up_idx (
    .pc_i   (up_pc_i),
    .hist_i (up_hist_i),
    .idx_o  (up_idx)
  );

  bp_ctr_table #(.N(N), .IW(IW)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .rd_ctr_o   (lk_ctr),
    .wr_en_i    (up_valid_i),
    .wr_idx_i   (up_idx),
    .wr_taken_i (up_dir == DIR_T),
    .wr_ctr_o   (up_ctr)
  );

  assign lk_taken_o = lk_ctr[N-1];
  assign lk_hist_o  = ghr;
endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk
  import bp_pkg::*;
#(
  parameter int unsigned M  = 2,
  parameter int unsigned N  = 2,
  parameter int unsigned HW = 2,
  parameter int unsigned IW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lk_taken_o,
  input logic [HW-1:0] lk_hist_o,
  input logic          up_valid_i,
  input logic          up_taken_i,
  input logic [IW-1:0] up_idx,
  input logic [N-1:0]  up_ctr
);
  logic seen_upd;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_upd <= 1'b0;
    else if (up_valid_i) seen_upd <= 1'b1;
  end

  p_reset_taken_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_upd |-> lk_taken_o);

  p_ctr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> (up_idx != $past(up_idx)) ||
                   (up_ctr == N'(sat_step(32'($past(up_ctr)), $past(up_taken_i), N))));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> (up_idx != $past(up_idx)) || $stable(up_ctr));

  if (M > 0) begin : g_h
    p_hist_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_valid_i |=> lk_hist_o == HW'({$past(lk_hist_o), $past(up_taken_i)}));
    p_hist_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !up_valid_i |=> $stable(lk_hist_o));
  end else begin : g_nh
    p_no_hist_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hist_o == '0);
  end
endmodule

bind corr_bp corr_bp_chk #(.M(M), .N(N), .HW(HW), .IW(M + K)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_taken_o (lk_taken_o),
  .lk_hist_o  (lk_hist_o),
  .up_valid_i (up_valid_i),
  .up_taken_i (up_taken_i),
  .up_idx     (up_idx),
  .up_ctr     (up_ctr)
);

// File: tb/sim_corr_bp.sv
`timescale 1ns/1ps
module sim_corr_bp;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] lk_pc = '0, up_pc = '0;
  logic        up_valid = 1'b0, up_taken = 1'b0;
  logic [1:0]  up_hist0 = '0;
  logic        up_hist1 = 1'b0;
  logic        pred0, pred1, hist1_o;
  logic [1:0]  hist0_o;

  corr_bp #(.M(2), .N(2), .K(4), .PC_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(pred0), .lk_hist_o(hist0_o),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_hist_i(up_hist0), .up_taken_i(up_taken));

  corr_bp #(.M(0), .N(3), .K(3), .PC_W(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(pred1), .lk_hist_o(hist1_o),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_hist_i(up_hist1), .up_taken_i(up_taken));

  int n_chk = 0, n_bad = 0;
  int unsigned c0 [64];
  int unsigned c1 [8];
  int unsigned h0 = 0;
  bit s0, s1;
  bit done = 0;

  function automatic int unsigned sat(int unsigned v, bit inc, int unsigned top);
    if (inc) return (v == top) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample lookup before the edge, apply model after it
  task automatic cyc(input logic [15:0] lpc, input bit v, input logic [15:0] upc,
                     input int unsigned hst, input bit t, input string req);
    int unsigned i0;
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    up_hist0 = 2'(hst); up_hist1 = 1'b0;
    #1;
    s0 = pred0; s1 = pred1;
    i0 = (h0 << 4) | (32'(lpc) & 15);
    chk(pred0 == (c0[i0] >= 2), req, "u0 pred", int'(pred0), int'(c0[i0] >= 2));
    chk(pred1 == (c1[32'(lpc) & 7] >= 4), req, "u1 pred", int'(pred1), int'(c1[32'(lpc) & 7] >= 4));
    chk(hist0_o == 2'(h0), "R6", "u0 hist", int'(hist0_o), int'(h0));
    chk(hist1_o == 1'b0, "R8", "u1 hist", int'(hist1_o), 0);
    @(posedge clk);
    if (v) begin
      i0 = ((hst & 3) << 4) | (32'(upc) & 15);
      c0[i0] = sat(c0[i0], t, 3);
      c1[32'(upc) & 7] = sat(c1[32'(upc) & 7], t, 7);
      h0 = ((h0 << 1) | 32'(t)) & 3;
    end
  endtask

  task automatic step(input logic [15:0] pc, input bit t, input string req);
    cyc(pc, 1, pc, h0, t, req);
  endtask
  task automatic peek(input logic [15:0] pc, input string req);
    cyc(pc, 0, 16'h0, 0, 0, req);
  endtask
  task automatic upd5(input bit t);
    cyc(16'h0, 1, 16'h0005, 0, t, "R4");
  endtask
  task automatic flush();
    cyc(16'h0009, 1, 16'h0009, h0, 0, "R6");
    cyc(16'h0009, 1, 16'h0009, h0, 0, "R6");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int miss0, miss1;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) c0[i] = 2;
    for (int i = 0; i < 8; i++) c1[i] = 4;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every entry weakly taken after reset
    for (int p = 0; p < 16; p++) begin
      peek(16'(p), "R1");
      chk(s0 == 1'b1, "R1", "u0 reset pred", int'(s0), 1);
      chk(s1 == 1'b1, "R1", "u1 reset pred", int'(s1), 1);
    end

    // R4/R5 on u0 entry {hist=0, pc=5}
    repeat (3) upd5(1'b1);
    flush(); peek(16'h0005, "R4");
    chk(s0 == 1'b1, "R4", "sat high pred", int'(s0), 1);
    upd5(1'b0);
    flush(); peek(16'h0005, "R5");
    chk(s0 == 1'b1, "R5", "one miss keeps taken", int'(s0), 1);
    peek(16'hFFF5, "R3");
    chk(s0 == 1'b1, "R3", "upper pc bits ignored", int'(s0), 1);
    upd5(1'b0);
    flush(); peek(16'h0005, "R5");
    chk(s0 == 1'b0, "R5", "two misses flip", int'(s0), 0);
    repeat (3) upd5(1'b0);
    upd5(1'b1);
    flush(); peek(16'h0005, "R4");
    chk(s0 == 1'b0, "R4", "sat low no wrap", int'(s0), 0);
    peek(16'h3AB5, "R3");
    chk(s0 == 1'b0, "R3", "upper pc bits ignored", int'(s0), 0);

    // R7: same-cycle update not visible, next cycle visible (u1, pc 6: 4 -> 3)
    cyc(16'h0006, 1, 16'h0006, h0, 0, "R7");
    chk(s1 == 1'b1, "R7", "pre-update lookup", int'(s1), 1);
    peek(16'h0006, "R7");
    chk(s1 == 1'b0, "R7", "post-update lookup", int'(s1), 0);

    // R10/R8: A alternates, B copies A
    miss0 = 0; miss1 = 0;
    for (int it = 0; it < 60; it++) begin
      bit a;
      a = bit'(it % 2);
      step(16'h1002, a, "R10");
      if (it >= 20 && s0 != a) miss0++;
      if (it >= 20 && s1 != a) miss1++;
      step(16'h2003, a, "R10");
      if (it >= 20 && s0 != a) miss0++;
      if (it >= 20 && s1 != a) miss1++;
    end
    chk(miss0 == 0, "R10", "correlated misses m=2", miss0, 0);
    chk(miss1 > 0, "R8", "flat table misses >0", miss1 > 0 ? 1 : 0, 1);

    // random mix: step / stale-history update / idle (R2 R3 R4 R6 R9)
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [15:0] pa, pb;
      r  = $urandom % 4;
      pa = 16'($urandom);
      pb = 16'($urandom);
      case (r)
        0, 1: step(pa, bit'($urandom % 2), "R2");
        2:    cyc(pa, 1, pb, $urandom % 4, bit'($urandom % 2), "R4");
        default: peek(pa, "R9");
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule